// File: doc/BRIEF.md
# Cascadable Prescaled Down-Counter Timer Pair

This block holds two identical 8-bit timer channels, A and B. Each channel divides a shared count tick by a 2-bit prescaler and then counts down an 8-bit decrementer. When the decrementer passes through zero it reloads and the channel raises a one-cycle interrupt pulse. The tick comes from either a quarter-rate divider of the core clock or a synchronized external clock pin. A cascade mode feeds channel A's underflows into channel B as B's tick. Together the two channels then form one long-period timer, and channel B's pulse marks the long period.

Each channel has a capture register. On the selected edge of its capture pin, the register takes the live decrementer value, unless the idle input is high. Channel B can also drive a port pin. In toggle mode the pin flips on every B underflow, and CPU writes to the port data bit are ignored. When toggle mode ends, the pin stays at the last toggled value and CPU writes take effect again.

Top module: `twin_dcount_timer`

## Requirements
- R1: With `tick_src_ext`=0 the count tick fires once every 4 core clocks. With `tick_src_ext`=1 it fires once per rising edge of `ext_clk`, and the ticks are single-cycle.
- R2: After a start, a channel's prescaler divides the tick by its `presc`+1, so a `presc` value of 0 to 3 gives a ratio of 1 to 4.
- R3: A running channel underflows once every (`presc`+1)×(`reload`+1) ticks and reloads on that same cycle. Its `irq` output is a one-cycle pulse on that cycle, and only while its `int_en` is 1.
- R4: With `cascade`=1, channel B counts channel A underflows in place of the tick. B's period is then the product of both channels' periods.
- R5: `cap_edge`=1 selects the rising edge of the capture pin and 0 selects the falling edge. On the selected edge the channel's current decrementer value is copied into `cap`. The other edge leaves `cap` unchanged.
- R6: While `idle`=1, no capture happens on either channel.
- R7: With `tog_en`=1, `port_pin` inverts on each channel B underflow, whatever `int_en_b` is.
- R8: A start pulse reloads the prescaler and decrementer and begins counting. It never changes `port_pin`.
- R9: While `tog_en`=1, `port_wr` has no effect on `port_pin`.
- R10: After `tog_en` returns to 0, `port_pin` keeps the last toggled value until a `port_wr` loads `port_wdata`.
- R11: After reset, both channels are stopped, `irq_a`/`irq_b` are 0, both `cap` registers are 0 and `port_pin` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_src_ext | input | 1 | 1 = external clock pin gives the tick, 0 = quarter-rate divider |
| ext_clk | input | 1 | External count clock pin |
| cascade | input | 1 | Chain channel A underflows into channel B |
| presc_a | input | 2 | Channel A prescale value |
| reload_a | input | 8 | Channel A reload value |
| start_a | input | 1 | Channel A start/reload pulse |
| int_en_a | input | 1 | Channel A interrupt enable |
| presc_b | input | 2 | Channel B prescale value |
| reload_b | input | 8 | Channel B reload value |
| start_b | input | 1 | Channel B start/reload pulse |
| int_en_b | input | 1 | Channel B interrupt enable |
| cap_pin_a | input | 1 | Channel A capture pin |
| cap_edge_a | input | 1 | Channel A edge select (1 rising, 0 falling) |
| cap_pin_b | input | 1 | Channel B capture pin |
| cap_edge_b | input | 1 | Channel B edge select (1 rising, 0 falling) |
| idle | input | 1 | Inhibits capture while high |
| tog_en | input | 1 | Port pin toggle mode |
| port_wr | input | 1 | CPU write strobe for the port data bit |
| port_wdata | input | 1 | CPU data for the port bit |
| irq_a | output | 1 | Channel A interrupt pulse |
| irq_b | output | 1 | Channel B interrupt pulse |
| cap_a | output | 8 | Channel A capture register |
| cap_b | output | 8 | Channel B capture register |
| port_pin | output | 1 | Port pin value, which is also the port data readback |

## Verification
A wrong prescaler or decrementer state shows as an interrupt spacing different from 4×(P+1)×(R+1) core clocks. It becomes visible at the very next pulse, so each period measurement catches it within one period. A wrong live count is exposed as soon as the external clock is frozen and a capture edge is applied, because the captured value must equal the reload value minus the number of external pulses. A lost or extra toggle changes `port_pin` at the next pair of external pulses. A port write that leaks through in toggle mode changes `port_pin` within one clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NCH  = 2;
  localparam int unsigned PW   = 2;
  localparam int unsigned CW   = 8;
  localparam int unsigned QDIV = 4;
  typedef logic [PW-1:0] presc_t;
  typedef logic [CW-1:0] count_t;
endpackage

// File: rtl/tmr_tickgen.sv
module tmr_tickgen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_ext,
  input  logic ext_clk,
  output logic tick
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q, div_d;
  logic          e1_q, e2_q, e3_q;
  logic          tick_q, tick_d;

  always_comb begin
    div_d  = (div_q == DW'(DIV-1)) ? '0 : div_q + DW'(1);
    tick_d = src_ext ? (e2_q & ~e3_q) : (div_q == DW'(DIV-1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      e1_q   <= 1'b0;
      e2_q   <= 1'b0;
      e3_q   <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      e1_q   <= ext_clk;
      e2_q   <= e1_q;
      e3_q   <= e2_q;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R1: a tick never lasts two cycles
  p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   start,
  input  presc_t presc,
  input  count_t reload,
  output logic   uf,
  output count_t count
);
  presc_t pre_q, pre_d;
  count_t dec_q, dec_d;
  logic   run_q, run_d;

  assign uf    = run_q & tick & ~start & (pre_q == '0) & (dec_q == '0);
  assign count = dec_q;

  always_comb begin
    pre_d = pre_q;
    dec_d = dec_q;
    run_d = run_q;
    if (start) begin
      pre_d = presc;
      dec_d = reload;
      run_d = 1'b1;
    end else if (run_q && tick) begin
      if (pre_q == '0) begin
        pre_d = presc;
        dec_d = (dec_q == '0) ? reload : dec_q - CW'(1);
      end else begin
        pre_d = pre_q - PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      dec_q <= '0;
      run_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      dec_q <= dec_d;
      run_q <= run_d;
    end
  end

  // R3: underflow reloads the decrementer on the same edge
  p_uf_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> (dec_q == $past(reload)) && (pre_q == $past(presc)));
  // R8: a start loads both stages and runs
  p_start_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (dec_q == $past(reload)) && (pre_q == $past(presc)) && run_q);
  // R2: without a tick the state holds
  p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(dec_q) && $stable(pre_q));
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
  import tmr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin,
  input  logic   rise_sel,
  input  logic   idle,
  input  count_t count,
  output count_t cap
);
  logic   s1_q, s2_q, prev_q;
  logic   hit;
  count_t cap_q, cap_d;

  assign hit = (s2_q != prev_q) && (s2_q == rise_sel) && !idle;

  always_comb begin
    cap_d = hit ? count : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      cap_q  <= cap_d;
    end
  end

  assign cap = cap_q;

  // R6: nothing is captured while idle
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(cap_q));
  // R5: without a level change the register holds
  p_no_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_q == prev_q) |=> $stable(cap_q));
endmodule

// File: rtl/tmr_pin.sv
module tmr_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_en,
  input  logic uf,
  input  logic wr,
  input  logic wdata,
  output logic pin
);
  logic pin_q, pin_d;

  always_comb begin
    pin_d = pin_q;
    if (tog_en) begin
      if (uf) pin_d = ~pin_q;
    end else if (wr) begin
      pin_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;

  // R7: each underflow in toggle mode flips the pin
  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_en && uf) |=> (pin_q != $past(pin_q)));
  // R9: CPU writes cannot move the pin in toggle mode
  p_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_en && !uf) |=> $stable(pin_q));
  // R10: out of toggle mode only a write changes the pin
  p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tog_en && !wr) |=> $stable(pin_q));
endmodule

// File: rtl/twin_dcount_timer.sv
module twin_dcount_timer
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_src_ext,
  input  logic       ext_clk,
  input  logic       cascade,
  input  logic [1:0] presc_a,
  input  logic [7:0] reload_a,
  input  logic       start_a,
  input  logic       int_en_a,
  input  logic [1:0] presc_b,
  input  logic [7:0] reload_b,
  input  logic       start_b,
  input  logic       int_en_b,
  input  logic       cap_pin_a,
  input  logic       cap_edge_a,
  input  logic       cap_pin_b,
  input  logic       cap_edge_b,
  input  logic       idle,
  input  logic       tog_en,
  input  logic       port_wr,
  input  logic       port_wdata,
  output logic       irq_a,
  output logic       irq_b,
  output logic [7:0] cap_a,
  output logic [7:0] cap_b,
  output logic       port_pin
);
  // reset: asserted asynchronously, released on a clock edge
  logic rs1_q, rs2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  logic base_tick;
  tmr_tickgen #(.DIV(QDIV)) i_tick (
    .clk(clk), .rst_n(rs2_q), .src_ext(tick_src_ext), .ext_clk(ext_clk),
    .tick(base_tick)
  );

  presc_t presc_v [NCH];
  count_t reload_v[NCH];
  count_t count_v [NCH];
  count_t cap_v   [NCH];
  logic   start_v [NCH];
  logic   uf_v    [NCH];
  logic   tick_v  [NCH];
  logic   pin_v   [NCH];
  logic   edge_v  [NCH];

  assign presc_v[0]  = presc_a;   assign presc_v[1]  = presc_b;
  assign reload_v[0] = reload_a;  assign reload_v[1] = reload_b;
  assign start_v[0]  = start_a;   assign start_v[1]  = start_b;
  assign pin_v[0]    = cap_pin_a; assign pin_v[1]    = cap_pin_b;
  assign edge_v[0]   = cap_edge_a; assign edge_v[1]  = cap_edge_b;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g == 0) begin : g_head
      assign tick_v[g] = base_tick;
    end else begin : g_chain
      assign tick_v[g] = cascade ? uf_v[g-1] : base_tick;
    end

    tmr_chan i_chan (
      .clk(clk), .rst_n(rs2_q), .tick(tick_v[g]), .start(start_v[g]),
      .presc(presc_v[g]), .reload(reload_v[g]), .uf(uf_v[g]), .count(count_v[g])
    );

    tmr_capture i_cap (
      .clk(clk), .rst_n(rs2_q), .pin(pin_v[g]), .rise_sel(edge_v[g]),
      .idle(idle), .count(count_v[g]), .cap(cap_v[g])
    );
  end

  tmr_pin i_pin (
    .clk(clk), .rst_n(rs2_q), .tog_en(tog_en), .uf(uf_v[NCH-1]),
    .wr(port_wr), .wdata(port_wdata), .pin(port_pin)
  );

  assign irq_a = uf_v[0] & int_en_a;
  assign irq_b = uf_v[NCH-1] & int_en_b;
  assign cap_a = cap_v[0];
  assign cap_b = cap_v[NCH-1];

  // R3: interrupt pulses last one cycle
  p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rs2_q)
    irq_a |=> !irq_a);
  // R4: in cascade, B only steps on an A underflow
  p_cascade_step_r4: assert property (@(posedge clk) disable iff (!rs2_q)
    (cascade && irq_b) |-> uf_v[0]);
endmodule

// File: tb/test_twin_dcount_timer.sv
`timescale 1ns/1ps
module test_twin_dcount_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_src_ext = 0, ext_clk = 0, cascade = 0;
  logic [1:0] presc_a = 0, presc_b = 0;
  logic [7:0] reload_a = 0, reload_b = 0;
  logic start_a = 0, start_b = 0, int_en_a = 0, int_en_b = 0;
  logic cap_pin_a = 0, cap_edge_a = 1, cap_pin_b = 0, cap_edge_b = 1;
  logic idle = 0, tog_en = 0, port_wr = 0, port_wdata = 0;
  logic irq_a, irq_b, port_pin;
  logic [7:0] cap_a, cap_b;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  twin_dcount_timer i_twin_dcount_timer (
    .clk(clk), .rst_n(rst_n), .tick_src_ext(tick_src_ext), .ext_clk(ext_clk),
    .cascade(cascade), .presc_a(presc_a), .reload_a(reload_a), .start_a(start_a),
    .int_en_a(int_en_a), .presc_b(presc_b), .reload_b(reload_b), .start_b(start_b),
    .int_en_b(int_en_b), .cap_pin_a(cap_pin_a), .cap_edge_a(cap_edge_a),
    .cap_pin_b(cap_pin_b), .cap_edge_b(cap_edge_b), .idle(idle), .tog_en(tog_en),
    .port_wr(port_wr), .port_wdata(port_wdata), .irq_a(irq_a), .irq_b(irq_b),
    .cap_a(cap_a), .cap_b(cap_b), .port_pin(port_pin)
  );

  // {presc[9:8], reload[7:0]}
  localparam logic [9:0] VEC [6] = '{
    {2'd0, 8'd0}, {2'd3, 8'd0}, {2'd0, 8'd4},
    {2'd1, 8'd4}, {2'd3, 8'd9}, {2'd2, 8'd255}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start(input bit b);
    @(negedge clk);
    if (b) start_b = 1; else start_a = 1;
    @(negedge clk);
    start_a = 0; start_b = 0;
  endtask

  task automatic ext_pulse(input int n);
    for (int k = 0; k < n; k++) begin
      ext_clk = 1; clks(4);
      ext_clk = 0; clks(4);
    end
  endtask

  // cycles between two consecutive pulses; -1 on timeout
  task automatic period(input bit b, output int cyc);
    int guard;
    guard = 0;
    cyc = -1;
    while (!(b ? irq_b : irq_a) && guard < 20000) begin @(negedge clk); guard++; end
    if (guard >= 20000) return;
    cyc = 0;
    do begin @(negedge clk); cyc++; end
    while (!(b ? irq_b : irq_a) && cyc < 20000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int p, seen;
    clks(3);
    rst_n = 1;
    clks(4);
    // R11: reset state
    chk(irq_a == 0 && irq_b == 0, "R11 irq", irq_a, 0);
    chk(cap_a == 0 && cap_b == 0, "R11 cap", cap_a + cap_b, 0);
    chk(port_pin == 0, "R11 pin", port_pin, 0);
    int_en_a = 1; int_en_b = 1;
    seen = 0;
    for (int k = 0; k < 60; k++) begin @(negedge clk); if (irq_a || irq_b) seen++; end
    chk(seen == 0, "R11 stopped", seen, 0);

    // R1 R2 R3: period table, internal tick
    for (int v = 0; v < 6; v++) begin
      presc_a = VEC[v][9:8]; reload_a = VEC[v][7:0];
      pulse_start(0);
      period(0, p);
      chk(p == 4 * (int'(VEC[v][9:8]) + 1) * (int'(VEC[v][7:0]) + 1),
          "R2/R3 period", p, 4 * (int'(VEC[v][9:8]) + 1) * (int'(VEC[v][7:0]) + 1));
    end

    // R3: pulse width one cycle
    presc_a = 0; reload_a = 2;
    pulse_start(0);
    while (!irq_a) @(negedge clk);
    @(negedge clk);
    chk(irq_a == 0, "R3 width", irq_a, 0);

    // R3: disabled interrupt stays low
    int_en_a = 0;
    seen = 0;
    for (int k = 0; k < 60; k++) begin @(negedge clk); if (irq_a) seen++; end
    chk(seen == 0, "R3 enable", seen, 0);
    int_en_a = 1;

    // R4: cascade
    cascade = 1;
    presc_a = 0; reload_a = 1; presc_b = 1; reload_b = 2;
    pulse_start(0); pulse_start(1);
    period(1, p);
    chk(p == 8 * 6, "R4 cascade", p, 48);
    cascade = 0;
    presc_b = 0; reload_b = 3;
    pulse_start(1);
    period(1, p);
    chk(p == 16, "R4 uncascaded", p, 16);

    // external tick, frozen counters
    tick_src_ext = 1;
    int_en_a = 0; int_en_b = 0;
    presc_a = 0; reload_a = 9;
    pulse_start(0);
    clks(4);
    cap_edge_a = 1; cap_pin_a = 1; clks(6);
    chk(cap_a == 9, "R5 rising capture", cap_a, 9);
    ext_pulse(3);
    cap_pin_a = 0; clks(6);
    chk(cap_a == 9, "R5 wrong edge ignored", cap_a, 9);
    cap_edge_a = 0;
    cap_pin_a = 1; clks(6);
    cap_pin_a = 0; clks(6);
    chk(cap_a == 6, "R1/R5 falling capture", cap_a, 6);
    idle = 1;
    ext_pulse(1);
    cap_pin_a = 1; clks(6);
    cap_pin_a = 0; clks(6);
    chk(cap_a == 6, "R6 idle", cap_a, 6);
    idle = 0;
    cap_pin_a = 1; clks(6);
    cap_pin_a = 0; clks(6);
    chk(cap_a == 5, "R6 after idle", cap_a, 5);
    reload_b = 7;
    pulse_start(1);
    clks(4);
    cap_edge_b = 1; cap_pin_b = 1; clks(6);
    chk(cap_b == 7, "R5 channel B", cap_b, 7);

    // R7 .. R10: pin toggle, B period 2 ext pulses
    port_wr = 1; port_wdata = 0; clks(1); port_wr = 0;
    reload_b = 1; presc_b = 0;
    tog_en = 1;
    pulse_start(1);
    clks(2);
    chk(port_pin == 0, "R8 start no toggle", port_pin, 0);
    ext_pulse(2);
    chk(port_pin == 1, "R7 toggle", port_pin, 1);
    ext_pulse(2);
    chk(port_pin == 0, "R7 toggle back", port_pin, 0);
    ext_pulse(1);
    pulse_start(1);
    clks(2);
    chk(port_pin == 0, "R8 restart no toggle", port_pin, 0);
    ext_pulse(2);
    chk(port_pin == 1, "R7 after restart", port_pin, 1);
    port_wdata = 0; port_wr = 1; clks(1); port_wr = 0; clks(1);
    chk(port_pin == 1, "R9 write ignored", port_pin, 1);
    tog_en = 0; clks(2);
    chk(port_pin == 1, "R10 keeps value", port_pin, 1);
    ext_pulse(2);
    chk(port_pin == 1, "R10 no toggle off", port_pin, 1);
    port_wdata = 0; port_wr = 1; clks(1); port_wr = 0; clks(1);
    chk(port_pin == 0, "R10 write takes", port_pin, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule